// File: doc/BRIEF.md
# Match Watchdog Timer

This block is a register-mapped watchdog. A 32-bit up-counter advances on a fixed-rate tick input and is compared with a programmable match value. Each match event can do any mix of four things: set an interrupt flag, change a match output pin, reset or stop the counter, and launch an internal and/or an external reset pulse. Each pulse lasts a programmable number of clock cycles. Software can also force either reset output directly. A sticky cause flag records that the internal reset output fired. Only a power-on reset input clears that flag, so software can read it after the watchdog reset has run.

The counter is run by a four-state controller. IDLE holds the count. RUN advances it. FLUSH clears it to zero. FROZEN holds it while a debug halt is requested. The transitions are as follows:
- IDLE→RUN when the enable bit is set.
- RUN→IDLE when the enable bit is cleared.
- RUN→FROZEN when freeze is enabled and the halt input is high.
- FROZEN→RUN when that condition goes away.
- FROZEN→IDLE when the enable bit is cleared.
- Any state→FLUSH on a clear request.
- FLUSH→RUN or FLUSH→IDLE, chosen by the enable bit. FLUSH goes to FROZEN instead of RUN when the freeze condition holds.

Each reset output has its own two-state pulse generator. IDLE→ACTIVE on a start request. ACTIVE→IDLE when its down-counter reaches zero.

Software arms the block by writing, in order: a clear request, the actions, the pulse width and the timeout. It then sets the enable bit. To keep the system alive, software repeats the clear request before the counter reaches the match value.

Top module: `match_watchdog`

## Requirements
- R1: After `rst_n` and `por_n` are both released, every register reads 0 and `irq`, `match_out`, `rst_int_o` and `rst_ext_o` are low. The registers are: 0x00 flag, 0x04 control, 0x08 counter, 0x0C action, 0x10 match, 0x14 pin control, 0x18 pulse width, 0x1C cause. Reads return 0 while `bus_rd` is low.
- R2: While control bit 0 (enable) is 1 and the counter is not frozen, the counter (0x08) grows by one on each clock with `tick` high. When `tick` is low or enable is 0, the counter holds.
- R3: A write to 0x04 with bit 1 set makes the counter read 0 two clock edges after the write edge. Bit 1 always reads back 0. With enable 0, the counter then stays 0.
- R4: While control bit 2 is 1 and `dbg_halt` is high, the counter holds. With bit 2 at 0, `dbg_halt` has no effect.
- R5: A match event happens once each time the counter, while enabled, becomes equal to 0x10. If action bit 0 is set, the event sets flag bit 0 and `irq` goes high. Writing 1 to bit 0 of 0x00 clears the flag. Writing 0 to that bit leaves it set.
- R6: With action bit 1 set, a match event returns the counter to 0. With action bit 2 set, a match event clears the enable bit and leaves the counter at the match value.
- R7: Action bit 3 (internal) and action bit 4 (external) start a pulse on the matching reset output in the cycle after the match event. The pulse lasts exactly the 16-bit width at 0x18 plus 2 cycles, and a new start is ignored while it runs.
- R8: Action bit 5 forces `rst_int_o` high and action bit 6 forces `rst_ext_o` high, for as long as the bit is set.
- R9: Bit 0 of 0x14 drives `match_out` and can be written. On a match event, the 2-bit field [5:4] acts on that bit: 0 leaves it, 1 clears it, 2 sets it, 3 inverts it.
- R10: Bit 0 of 0x1C sets when `rst_int_o` is high. Writes to it are ignored and `rst_n` does not clear it; only `por_n` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears the cause flag |
| tick | input | 1 | Counter advance qualifier (fixed-rate tick) |
| dbg_halt | input | 1 | Debug halt request |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | Match output pin |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |

## Verification
The match path is driven with the pin field set to each of its four codes, and each code is tried with the pin first at 0 and then at 1. This separates hold, clear, set and invert, which are indistinguishable when only one starting value is used. Counting is tried in four conditions: with tick held high, with tick low, with freeze enabled and halt high, and with halt high but freeze disabled. Together these show which qualifier gates the counter. Each match action (flag, counter reset, stop, internal pulse, external pulse) is armed on its own, and pulse widths of 0 and 5 pin down the fixed two-cycle overhead. The cause flag is checked across a write to its register, a system reset and a power-on reset, which shows that only the last of these clears it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int OFS_FLAG  = 'h00;
    localparam int OFS_CTRL  = 'h04;
    localparam int OFS_CNT   = 'h08;
    localparam int OFS_ACT   = 'h0C;
    localparam int OFS_MATCH = 'h10;
    localparam int OFS_PIN   = 'h14;
    localparam int OFS_PW    = 'h18;
    localparam int OFS_CAUSE = 'h1C;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_RUN    = 2'd1,
        CS_FLUSH  = 2'd2,
        CS_FROZEN = 2'd3
    } cnt_state_e;

    typedef enum logic {
        PS_IDLE   = 1'b0,
        PS_ACTIVE = 1'b1
    } pulse_state_e;

    typedef enum logic [1:0] {
        PA_KEEP   = 2'd0,
        PA_LOW    = 2'd1,
        PA_HIGH   = 2'd2,
        PA_INVERT = 2'd3
    } pin_act_e;
endpackage

// File: rtl/wdt_count_fsm.sv
module wdt_count_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             freeze_en,
    input  logic             dbg_halt,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] match_val,
    input  logic             rst_on_match,
    input  logic             stop_on_match,
    output logic [CNT_W-1:0] cnt_val,
    output logic             match_hit,
    output cnt_state_e       state_o
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             eq_q;
    logic             frz;
    logic             eq_now;
    logic             advance;

    assign frz = freeze_en & dbg_halt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (clr_req)     state_d = CS_FLUSH;
                else if (cnt_en) state_d = frz ? CS_FROZEN : CS_RUN;
            end
            CS_RUN: begin
                if (clr_req)      state_d = CS_FLUSH;
                else if (!cnt_en) state_d = CS_IDLE;
                else if (frz)     state_d = CS_FROZEN;
            end
            CS_FROZEN: begin
                if (clr_req)      state_d = CS_FLUSH;
                else if (!cnt_en) state_d = CS_IDLE;
                else if (!frz)    state_d = CS_RUN;
            end
            CS_FLUSH: begin
                if (clr_req)     state_d = CS_FLUSH;
                else if (cnt_en) state_d = frz ? CS_FROZEN : CS_RUN;
                else             state_d = CS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        eq_now    = (state_q == CS_RUN) && cnt_en && (cnt_q == match_val);
        match_hit = eq_now && !eq_q;
        advance   = (state_q == CS_RUN) && cnt_en && !frz && tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            eq_q <= eq_now;
            if (state_q == CS_FLUSH)            cnt_q <= '0;
            else if (match_hit && rst_on_match) cnt_q <= '0;
            else if (match_hit && stop_on_match) cnt_q <= cnt_q;
            else if (advance)                   cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_val = cnt_q;
    assign state_o = state_q;
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
    import wdt_pkg::*;
#(
    parameter int PW_W  = 16,
    parameter int EXTRA = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PW_W-1:0] width,
    output logic            active
);
    localparam int LW = PW_W + 2;

    pulse_state_e   state_q, state_d;
    logic [LW-1:0]  remain_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (start) state_d = PS_ACTIVE;
            PS_ACTIVE: if (remain_q == '0) state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (state_q == PS_IDLE) begin
            if (start) remain_q <= LW'(width) + LW'(EXTRA - 1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - LW'(1);
        end
    end

    // outputs
    always_comb active = (state_q == PS_ACTIVE);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PW_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              match_hit,
    input  logic              cause_q,
    output logic              cnt_en,
    output logic              freeze_en,
    output logic              clr_req,
    output logic [6:0]        act_bits,
    output logic [CNT_W-1:0]  match_val,
    output logic [PW_W-1:0]   pulse_w,
    output logic              irq,
    output logic              match_out
);
    localparam int ACT_W = 7;

    logic              en_q, frz_q, flag_q, pin_q, pin_d;
    logic [ACT_W-1:0]  act_q;
    logic [CNT_W-1:0]  match_q;
    logic [PW_W-1:0]   pw_q;
    pin_act_e          pin_act_q;
    logic              wr_flag, wr_ctrl, wr_act, wr_match, wr_pin, wr_pw;

    assign wr_flag  = wr_en && (addr == ADDR_W'(OFS_FLAG));
    assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_act   = wr_en && (addr == ADDR_W'(OFS_ACT));
    assign wr_match = wr_en && (addr == ADDR_W'(OFS_MATCH));
    assign wr_pin   = wr_en && (addr == ADDR_W'(OFS_PIN));
    assign wr_pw    = wr_en && (addr == ADDR_W'(OFS_PW));

    assign clr_req  = wr_ctrl && wdata[1];

    always_comb begin
        pin_d = pin_q;
        if (match_hit) begin
            unique case (pin_act_q)
                PA_KEEP:   pin_d = pin_q;
                PA_LOW:    pin_d = 1'b0;
                PA_HIGH:   pin_d = 1'b1;
                PA_INVERT: pin_d = ~pin_q;
            endcase
        end else if (wr_pin) begin
            pin_d = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            frz_q     <= 1'b0;
            flag_q    <= 1'b0;
            pin_q     <= 1'b0;
            act_q     <= '0;
            match_q   <= '0;
            pw_q      <= '0;
            pin_act_q <= PA_KEEP;
        end else begin
            pin_q <= pin_d;
            if (wr_ctrl) begin
                en_q  <= wdata[0];
                frz_q <= wdata[2];
            end else if (match_hit && act_q[2]) begin
                en_q <= 1'b0;
            end
            if (match_hit && act_q[0])   flag_q <= 1'b1;
            else if (wr_flag && wdata[0]) flag_q <= 1'b0;
            if (wr_act)   act_q     <= wdata[ACT_W-1:0];
            if (wr_match) match_q   <= CNT_W'(wdata);
            if (wr_pw)    pw_q      <= wdata[PW_W-1:0];
            if (wr_pin)   pin_act_q <= pin_act_e'(wdata[5:4]);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_FLAG):  rdata = DATA_W'(flag_q);
                ADDR_W'(OFS_CTRL):  rdata = DATA_W'({frz_q, 1'b0, en_q});
                ADDR_W'(OFS_CNT):   rdata = DATA_W'(cnt_val);
                ADDR_W'(OFS_ACT):   rdata = DATA_W'(act_q);
                ADDR_W'(OFS_MATCH): rdata = DATA_W'(match_q);
                ADDR_W'(OFS_PIN):   rdata = DATA_W'({pin_act_q, 3'b000, pin_q});
                ADDR_W'(OFS_PW):    rdata = DATA_W'(pw_q);
                ADDR_W'(OFS_CAUSE): rdata = DATA_W'(cause_q);
                default:            rdata = '0;
            endcase
        end
    end

    assign cnt_en    = en_q;
    assign freeze_en = frz_q;
    assign act_bits  = act_q;
    assign match_val = match_q;
    assign pulse_w   = pw_q;
    assign irq       = flag_q;
    assign match_out = pin_q;
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int PW_W        = 16,
    parameter int PULSE_EXTRA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick,
    input  logic              dbg_halt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              match_out,
    output logic              rst_int_o,
    output logic              rst_ext_o
);
    localparam int N_RST = 2;

    logic             cnt_en, freeze_en, clr_req, match_hit, cause_q;
    logic [6:0]       act_bits;
    logic [CNT_W-1:0] match_val, cnt_val;
    logic [PW_W-1:0]  pulse_w;
    logic [N_RST-1:0] pulse_start, pulse_act, pulse_force;
    cnt_state_e       cnt_state;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PW_W(PW_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .cnt_val(cnt_val), .match_hit(match_hit), .cause_q(cause_q),
        .cnt_en(cnt_en), .freeze_en(freeze_en), .clr_req(clr_req),
        .act_bits(act_bits), .match_val(match_val), .pulse_w(pulse_w),
        .irq(irq), .match_out(match_out)
    );

    wdt_count_fsm #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_en(cnt_en), .freeze_en(freeze_en), .dbg_halt(dbg_halt),
        .clr_req(clr_req), .match_val(match_val),
        .rst_on_match(act_bits[1]), .stop_on_match(act_bits[2]),
        .cnt_val(cnt_val), .match_hit(match_hit), .state_o(cnt_state)
    );

    // index 0: internal reset, index 1: external reset
    for (genvar g = 0; g < N_RST; g++) begin : g_rst
        assign pulse_start[g] = match_hit && act_bits[3 + g];
        assign pulse_force[g] = act_bits[5 + g];
        wdt_pulse_gen #(.PW_W(PW_W), .EXTRA(PULSE_EXTRA)) u_pulse (
            .clk(clk), .rst_n(rst_n),
            .start(pulse_start[g]), .width(pulse_w),
            .active(pulse_act[g])
        );
    end

    assign rst_int_o = pulse_act[0] | pulse_force[0];
    assign rst_ext_o = pulse_act[1] | pulse_force[1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         cause_q <= 1'b0;
        else if (rst_int_o) cause_q <= 1'b1;
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  cnt_val,
    input cnt_state_e        cnt_state,
    input logic              match_hit,
    input logic              stop_on_match,
    input logic              rst_on_match,
    input logic              irq,
    input logic              ext_pulse,
    input logic              rst_int_o,
    input logic              cause_q
);
    logic wr_ctrl, wr_clr, wr_flag1;
    assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_clr   = wr_ctrl && wdata[1];
    assign wr_flag1 = wr_en && (addr == ADDR_W'(OFS_FLAG)) && wdata[0];

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_val) |-> (cnt_val == $past(cnt_val) + CNT_W'(1)) || (cnt_val == '0));

    assert_clr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ##1 (cnt_val == '0));

    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CS_FROZEN) |=> $stable(cnt_val));

    assert_hit_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> !match_hit);

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag1 && !match_hit) |=> !irq);

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && stop_on_match && !rst_on_match && !wr_ctrl) |=> (cnt_val == $past(cnt_val)));

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_pulse) |-> $past(match_hit));

    assert_cause_set_R10: assert property (@(posedge clk) disable iff (!por_n)
        rst_int_o |=> cause_q);
endmodule

bind match_watchdog wdt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_wdt_checker (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .addr(bus_addr), .wr_en(bus_wr), .wdata(bus_wdata),
    .cnt_val(cnt_val), .cnt_state(cnt_state), .match_hit(match_hit),
    .stop_on_match(act_bits[2]), .rst_on_match(act_bits[1]),
    .irq(irq), .ext_pulse(pulse_act[1]), .rst_int_o(rst_int_o),
    .cause_q(cause_q)
);

// File: tb/test_match_watchdog.sv
module test_match_watchdog;
    logic        clk = 1'b0;
    logic        rst_n, por_n, tick, dbg_halt;
    logic [4:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, match_out, rst_int_o, rst_ext_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    match_watchdog i_match_watchdog (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .match_out(match_out), .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
    );

    // {start pin, action code, expected pin after one match}
    localparam logic [3:0] PIN_VEC [8] = '{
        4'b0_00_0, 4'b1_00_1, 4'b0_01_0, 4'b1_01_0,
        4'b0_10_1, 4'b1_10_1, 4'b0_11_1, 4'b1_11_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, c1, c2, mx;
        int k;
        rst_n = 0; por_n = 0; tick = 1; dbg_halt = 0;
        bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        wait_cycles(4);
        rst_n = 1; por_n = 1;
        wait_cycles(1);

        // R1 reset state of every register and output
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), d);
            check("R1 reg", d, 32'h0);
        end
        check("R1 outputs", {28'h0, irq, match_out, rst_int_o, rst_ext_o}, 32'h0);
        bus_addr = 5'h08; #1 check("R1 rd low", bus_rdata, 32'h0);

        // R9 table of pin actions
        for (int i = 0; i < 8; i++) begin
            wr(5'h04, 32'h2);
            wr(5'h0C, 32'h0);
            wr(5'h10, 32'd6);
            wr(5'h14, {26'h0, PIN_VEC[i][2:1], 3'b000, PIN_VEC[i][3]});
            check("R9 pin write", {31'h0, match_out}, {31'h0, PIN_VEC[i][3]});
            wr(5'h04, 32'h1);
            wait_cycles(20);
            check("R9 pin action", {31'h0, match_out}, {31'h0, PIN_VEC[i][0]});
        end

        // R2 counting
        wr(5'h04, 32'h2);
        wr(5'h10, 32'hFFFF_0000);
        wr(5'h04, 32'h1);
        wait_cycles(3);
        rd(5'h08, c1); wait_cycles(9); rd(5'h08, c2);
        check("R2 advance", c2 - c1, 32'd9);
        tick = 0;
        rd(5'h08, c1); wait_cycles(5); rd(5'h08, c2);
        check("R2 tick low hold", c2, c1);
        tick = 1;
        wr(5'h04, 32'h0);
        rd(5'h08, c1); wait_cycles(5); rd(5'h08, c2);
        check("R2 disabled hold", c2, c1);

        // R3 clear request
        wr(5'h04, 32'h2);
        wait_cycles(1);
        rd(5'h08, d); check("R3 cleared", d, 32'h0);
        rd(5'h04, d); check("R3 self-clear", d, 32'h0);
        wait_cycles(10);
        rd(5'h08, d); check("R3 stays zero", d, 32'h0);

        // R4 debug freeze
        dbg_halt = 1;
        wr(5'h04, 32'h5);
        rd(5'h08, c1); wait_cycles(10); rd(5'h08, c2);
        check("R4 frozen", c2, c1);
        dbg_halt = 0;
        wait_cycles(3);
        rd(5'h08, c1); wait_cycles(5); rd(5'h08, c2);
        check("R4 released", c2 - c1, 32'd5);
        wr(5'h04, 32'h1);
        dbg_halt = 1;
        wait_cycles(2);
        rd(5'h08, c1); wait_cycles(5); rd(5'h08, c2);
        check("R4 halt ignored", c2 - c1, 32'd5);
        dbg_halt = 0;

        // R5 interrupt flag
        wr(5'h04, 32'h2);
        wr(5'h10, 32'd20);
        wr(5'h0C, 32'h1);
        wr(5'h04, 32'h1);
        k = 0;
        while (!irq && k < 100) begin wait_cycles(1); k++; end
        check("R5 irq raised", {31'h0, irq}, 32'h1);
        rd(5'h00, d); check("R5 flag", d, 32'h1);
        wr(5'h00, 32'h0);
        check("R5 write 0 keeps", {31'h0, irq}, 32'h1);
        wr(5'h00, 32'h1);
        check("R5 cleared", {31'h0, irq}, 32'h0);
        wait_cycles(20);
        check("R5 once per event", {31'h0, irq}, 32'h0);

        // R6 reset and stop on match
        wr(5'h04, 32'h2);
        wr(5'h0C, 32'h2);
        wr(5'h10, 32'd10);
        wr(5'h04, 32'h1);
        mx = 0;
        for (int j = 0; j < 60; j++) begin
            rd(5'h08, d);
            if (d > mx) mx = d;
            wait_cycles(1);
        end
        check("R6 reset on match", mx, 32'd10);
        wr(5'h04, 32'h2);
        wr(5'h0C, 32'h4);
        wr(5'h10, 32'd15);
        wr(5'h04, 32'h1);
        wait_cycles(40);
        rd(5'h08, d); check("R6 stop value", d, 32'd15);
        rd(5'h04, d); check("R6 enable cleared", d, 32'h0);

        // R7 reset pulses
        wr(5'h04, 32'h2);
        wr(5'h18, 32'd5);
        wr(5'h0C, 32'h10);
        wr(5'h10, 32'd8);
        wr(5'h04, 32'h1);
        k = 0;
        while (!rst_ext_o && k < 100) begin wait_cycles(1); k++; end
        check("R7 int quiet", {31'h0, rst_int_o}, 32'h0);
        k = 0;
        while (rst_ext_o && k < 1000) begin wait_cycles(1); k++; end
        check("R7 ext width", 32'(k), 32'd7);
        rd(5'h1C, d); check("R10 ext no cause", d, 32'h0);
        wr(5'h04, 32'h2);
        wr(5'h18, 32'd0);
        wr(5'h0C, 32'h08);
        wr(5'h04, 32'h1);
        k = 0;
        while (!rst_int_o && k < 100) begin wait_cycles(1); k++; end
        k = 0;
        while (rst_int_o && k < 1000) begin wait_cycles(1); k++; end
        check("R7 int width", 32'(k), 32'd2);

        // R10 cause flag
        rd(5'h1C, d); check("R10 cause set", d, 32'h1);
        wr(5'h1C, 32'h0);
        rd(5'h1C, d); check("R10 write ignored", d, 32'h1);

        // R8 forced outputs
        wr(5'h04, 32'h2);
        wr(5'h0C, 32'h40);
        check("R8 ext forced", {30'h0, rst_int_o, rst_ext_o}, 32'h1);
        wr(5'h0C, 32'h20);
        check("R8 int forced", {30'h0, rst_int_o, rst_ext_o}, 32'h2);
        wr(5'h0C, 32'h0);
        check("R8 released", {30'h0, rst_int_o, rst_ext_o}, 32'h0);

        // R10 survives system reset, cleared by power-on reset
        @(negedge clk); rst_n = 0;
        wait_cycles(2); rst_n = 1;
        wait_cycles(1);
        rd(5'h1C, d); check("R10 survives rst_n", d, 32'h1);
        rd(5'h10, d); check("R1 rst_n clears match", d, 32'h0);
        por_n = 0;
        wait_cycles(2); por_n = 1;
        wait_cycles(1);
        rd(5'h1C, d); check("R10 por clears", d, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule